// File: doc/BRIEF.md
# Load/Store Queue Occupancy Tracker

This block keeps the bookkeeping for the load queue and the store queue of one hardware thread. It holds no data and compares no addresses. It owns the circular head and tail pointers, the occupancy counts and, for every slot, the sequence number of the memory operation that fills it. Each queue has one slot more than its usable capacity, and that spare slot is never filled. A load slot is returned when its load commits. A store slot is kept until the store has been written back, and a third store pointer walks the committed stores in order as they are handed to memory.

The surrounding pipeline allocates a slot with an insert pulse and a sequence number. It receives the slot index on the tail outputs in the same cycle. Commit is given as a bound: every entry whose sequence number is at or below the bound is committed. The bound is held, and the tracker walks one load and one store per cycle from the oldest end. A squash is also given as a bound. From the next cycle the tracker removes younger entries from the tail, one per queue per cycle. While it does so it reports busy and refuses inserts. Commit walking pauses while a squash runs.

Top module: `lsq_occupancy`

## Requirements
- R1: After reset both counts are 0, every pointer is at slot 0, no full flag is set, the free-entry output equals the smaller configured capacity, no store is pending writeback, the writeback-ready and squash-busy outputs are low, and there is no allocation error.
- R2: An accepted insert takes the slot shown on that queue's tail output in that cycle. After the clock edge the tail has moved one slot forward and the count has risen by one.
- R3: A queue is full when its count equals its configured capacity. The overall full output is the OR of the two queue-full flags. The free-entry output is the smaller of (load capacity − load count) and (store capacity − store count).
- R4: An insert into a full queue, an insert while a squash is busy, or an insert in the same cycle as a squash request is dropped. The queue is unchanged and the allocation-error output is high for the following cycle. An accepted insert leaves that output low.
- R5: From the cycle after a commit request, the oldest load is freed once per cycle while its sequence number is at or below the held bound. If an insert and a free fall in the same cycle, the count changes by their net effect.
- R6: From the cycle after a commit request, the oldest uncommitted store is marked committed once per cycle while its sequence number is at or below the held bound. Each such mark adds one to the pending-writeback count and leaves the store count unchanged.
- R7: Writeback-ready is high exactly when the store at the writeback pointer is committed and not yet sent. A send pulse while ready moves the writeback pointer one slot forward and lowers the pending-writeback count by one. A send pulse while not ready is ignored.
- R8: A writeback-done pulse frees the store at the store head only if at least one store has been sent and not yet freed. Otherwise it is ignored.
- R9: A squash request raises squash-busy from the next cycle. While busy, each queue drops its newest entry once per cycle if that entry's sequence number is above the squash bound. Committed stores are never dropped. Busy falls in the cycle after neither queue has anything left to drop.
- R10: Every pointer steps from slot (capacity) back to slot 0, so that a queue of capacity N cycles through N+1 slot indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_ins | input | 1 | Insert a load |
| ld_ins_seq | input | SEQ_W | Sequence number of the inserted load |
| st_ins | input | 1 | Insert a store |
| st_ins_seq | input | SEQ_W | Sequence number of the inserted store |
| commit_req | input | 1 | Load a new commit bound |
| commit_seq | input | SEQ_W | Commit bound (inclusive) |
| squash_req | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Squash bound; entries above it are removed |
| wb_send | input | 1 | Store at the writeback pointer handed to memory |
| wb_done | input | 1 | Oldest sent store finished writeback |
| ld_count | output | clog2(LQ_ENTRIES+2) | Loads held |
| st_count | output | clog2(SQ_ENTRIES+2) | Stores held |
| ld_full | output | 1 | Load queue full |
| st_full | output | 1 | Store queue full |
| lsq_full | output | 1 | Either queue full |
| free_entries | output | clog2(max capacity+1) | Smaller of the two free counts |
| st_pending_wb | output | clog2(SQ_ENTRIES+2) | Committed stores not yet sent |
| wb_ready | output | 1 | A store can be sent this cycle |
| wb_idx | output | clog2(SQ_ENTRIES+1) | Writeback pointer |
| squash_busy | output | 1 | Squash in progress |
| ld_head_idx | output | clog2(LQ_ENTRIES+1) | Oldest load slot |
| ld_tail_idx | output | clog2(LQ_ENTRIES+1) | Slot the next load takes |
| st_head_idx | output | clog2(SQ_ENTRIES+1) | Oldest store slot |
| st_tail_idx | output | clog2(SQ_ENTRIES+1) | Slot the next store takes |
| alloc_err | output | 1 | Previous cycle dropped an insert |

## Verification
Both queues are filled one entry at a time up to capacity and then pushed once more. This separates the count, full and free arithmetic from the rejection path. A run of insert, commit, send and done rounds walks every pointer through its wrap point several times. A commit issued one cycle before an insert shows whether the count takes the net of a free and an allocation. The squash patterns use a bound in the middle of mixed loads and stores, and then a bound below a committed store. They tell apart per-cycle tail removal, insert blocking during the squash, and the protection of committed stores. Sends and dones issued when nothing qualifies check that those pulses are ignored.

// File: rtl/lsqt_pkg.sv
package lsqt_pkg;

  // Circular step over a ring of n slots, forward or backward.
  function automatic int unsigned slot_step(int unsigned p, int unsigned n, bit fwd);
    if (fwd) return (p + 1 == n) ? 0 : p + 1;
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/lsqt_rst_sync.sv
module lsqt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/lsqt_ring.sv
module lsqt_ring
  import lsqt_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned SEQ_W   = 8,
  localparam int unsigned SLOTS  = ENTRIES + 1,
  localparam int unsigned PW     = $clog2(ENTRIES + 1),
  localparam int unsigned CW     = $clog2(ENTRIES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             pop,
  input  logic             retreat,
  input  logic [PW-1:0]    rd_idx,
  output logic [PW-1:0]    head_o,
  output logic [PW-1:0]    tail_o,
  output logic [CW-1:0]    count_o,
  output logic [SEQ_W-1:0] rd_seq_o,
  output logic [SEQ_W-1:0] last_seq_o
);

  logic [PW-1:0]    head_q, head_d, tail_q, tail_d, last_idx;
  logic [CW-1:0]    count_q, count_d;
  logic [SEQ_W-1:0] seq_q [SLOTS];

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    if (pop)     head_d = PW'(slot_step(int'(head_q), SLOTS, 1'b1));
    if (push)    tail_d = PW'(slot_step(int'(tail_q), SLOTS, 1'b1));
    if (retreat) tail_d = last_idx;
    count_d = count_q + CW'(push) - CW'(pop) - CW'(retreat);
  end

  assign last_idx = PW'(slot_step(int'(tail_q), SLOTS, 1'b0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // Sequence storage: data only, no reset, written with an explicit enable.
  always_ff @(posedge clk) begin
    if (push) seq_q[tail_q] <= push_seq;
  end

  assign head_o     = head_q;
  assign tail_o     = tail_q;
  assign count_o    = count_q;
  assign rd_seq_o   = seq_q[rd_idx];
  assign last_seq_o = seq_q[last_idx];

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(ENTRIES));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count_q == $past(count_q) + CW'(1));
  a_r5_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || retreat) |-> count_q != '0);
  a_r9_no_push_in_squash: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && retreat));
  a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q < PW'(SLOTS)) && (tail_q < PW'(SLOTS)));
endmodule

// File: rtl/lsqt_st_track.sv
module lsqt_st_track
  import lsqt_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned SEQ_W   = 8,
  localparam int unsigned SLOTS  = ENTRIES + 1,
  localparam int unsigned PW     = $clog2(ENTRIES + 1),
  localparam int unsigned CW     = $clog2(ENTRIES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PW-1:0]    tail_idx,
  input  logic [CW-1:0]    count,
  input  logic             cmt_en,
  input  logic [SEQ_W-1:0] cmt_bound,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             send_req,
  input  logic             done_req,
  output logic [PW-1:0]    cmt_idx,
  output logic             pop_ok,
  output logic             has_uncommitted,
  output logic             will_wb,
  output logic [PW-1:0]    wb_idx,
  output logic [CW-1:0]    to_wb
);

  logic [SLOTS-1:0] flag_q, flag_d;
  logic [PW-1:0]    cmt_ptr_q, cmt_ptr_d, wb_ptr_q, wb_ptr_d;
  logic [CW-1:0]    cmt_cnt_q, cmt_cnt_d, sent_q, sent_d, to_wb_q, to_wb_d;
  logic             adv, send_ok;

  assign has_uncommitted = cmt_cnt_q < count;
  assign adv     = cmt_en && has_uncommitted && (cmt_seq <= cmt_bound);
  assign will_wb = flag_q[wb_ptr_q] && (sent_q < count);
  assign send_ok = send_req && will_wb;
  assign pop_ok  = done_req && (sent_q != '0);

  always_comb begin
    cmt_ptr_d = cmt_ptr_q;
    wb_ptr_d  = wb_ptr_q;
    if (adv)     cmt_ptr_d = PW'(slot_step(int'(cmt_ptr_q), SLOTS, 1'b1));
    if (send_ok) wb_ptr_d  = PW'(slot_step(int'(wb_ptr_q), SLOTS, 1'b1));
    cmt_cnt_d = cmt_cnt_q + CW'(adv) - CW'(pop_ok);
    sent_d    = sent_q + CW'(send_ok) - CW'(pop_ok);
    to_wb_d   = to_wb_q + CW'(adv) - CW'(send_ok);
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (push && tail_idx == PW'(i))     flag_d[i] = 1'b0;
      else if (adv && cmt_ptr_q == PW'(i)) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= '0;
      cmt_ptr_q <= '0;
      wb_ptr_q  <= '0;
      cmt_cnt_q <= '0;
      sent_q    <= '0;
      to_wb_q   <= '0;
    end else begin
      flag_q    <= flag_d;
      cmt_ptr_q <= cmt_ptr_d;
      wb_ptr_q  <= wb_ptr_d;
      cmt_cnt_q <= cmt_cnt_d;
      sent_q    <= sent_d;
      to_wb_q   <= to_wb_d;
    end
  end

  assign cmt_idx = cmt_ptr_q;
  assign wb_idx  = wb_ptr_q;
  assign to_wb   = to_wb_q;

  a_r7_tally: assert property (@(posedge clk) disable iff (!rst_n)
    to_wb_q + sent_q == cmt_cnt_q);
  a_r7_ready_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    will_wb |-> to_wb_q != '0);
  a_r8_sent_within_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q <= cmt_cnt_q) && (cmt_cnt_q <= count));
  a_r6_commit_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !send_ok) |=> to_wb_q == $past(to_wb_q) + CW'(1));
endmodule

// File: rtl/lsq_occupancy.sv
module lsq_occupancy #(
  parameter int unsigned LQ_ENTRIES = 4,
  parameter int unsigned SQ_ENTRIES = 4,
  parameter int unsigned SEQ_W      = 8,
  localparam int unsigned LPW = $clog2(LQ_ENTRIES + 1),
  localparam int unsigned LCW = $clog2(LQ_ENTRIES + 2),
  localparam int unsigned SPW = $clog2(SQ_ENTRIES + 1),
  localparam int unsigned SCW = $clog2(SQ_ENTRIES + 2),
  localparam int unsigned MAXE = (LQ_ENTRIES > SQ_ENTRIES) ? LQ_ENTRIES : SQ_ENTRIES,
  localparam int unsigned FW  = $clog2(MAXE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ins,
  input  logic [SEQ_W-1:0] ld_ins_seq,
  input  logic             st_ins,
  input  logic [SEQ_W-1:0] st_ins_seq,
  input  logic             commit_req,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_req,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             wb_send,
  input  logic             wb_done,
  output logic [LCW-1:0]   ld_count,
  output logic [SCW-1:0]   st_count,
  output logic             ld_full,
  output logic             st_full,
  output logic             lsq_full,
  output logic [FW-1:0]    free_entries,
  output logic [SCW-1:0]   st_pending_wb,
  output logic             wb_ready,
  output logic [SPW-1:0]   wb_idx,
  output logic             squash_busy,
  output logic [LPW-1:0]   ld_head_idx,
  output logic [LPW-1:0]   ld_tail_idx,
  output logic [SPW-1:0]   st_head_idx,
  output logic [SPW-1:0]   st_tail_idx,
  output logic             alloc_err
);

  logic             rst_i_n;
  logic             cmt_v_q, cmt_v_d, busy_q, busy_d, err_q, err_d;
  logic [SEQ_W-1:0] cmt_bound_q, cmt_bound_d, sq_bound_q, sq_bound_d;
  logic             ld_ok, st_ok, ld_pop, rm_ld, rm_st, cmt_en;
  logic             st_pop, st_has_unc;
  logic [SEQ_W-1:0] ld_head_seq, ld_last_seq, st_cmt_seq, st_last_seq;
  logic [SPW-1:0]   st_cmt_idx;

  lsqt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  lsqt_ring #(.ENTRIES(LQ_ENTRIES), .SEQ_W(SEQ_W)) u_lq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .push       (ld_ok),
    .push_seq   (ld_ins_seq),
    .pop        (ld_pop),
    .retreat    (rm_ld),
    .rd_idx     (ld_head_idx),
    .head_o     (ld_head_idx),
    .tail_o     (ld_tail_idx),
    .count_o    (ld_count),
    .rd_seq_o   (ld_head_seq),
    .last_seq_o (ld_last_seq)
  );

  lsqt_ring #(.ENTRIES(SQ_ENTRIES), .SEQ_W(SEQ_W)) u_sq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .push       (st_ok),
    .push_seq   (st_ins_seq),
    .pop        (st_pop),
    .retreat    (rm_st),
    .rd_idx     (st_cmt_idx),
    .head_o     (st_head_idx),
    .tail_o     (st_tail_idx),
    .count_o    (st_count),
    .rd_seq_o   (st_cmt_seq),
    .last_seq_o (st_last_seq)
  );

  lsqt_st_track #(.ENTRIES(SQ_ENTRIES), .SEQ_W(SEQ_W)) u_sw (
    .clk             (clk),
    .rst_n           (rst_i_n),
    .push            (st_ok),
    .tail_idx        (st_tail_idx),
    .count           (st_count),
    .cmt_en          (cmt_en),
    .cmt_bound       (cmt_bound_q),
    .cmt_seq         (st_cmt_seq),
    .send_req        (wb_send),
    .done_req        (wb_done),
    .cmt_idx         (st_cmt_idx),
    .pop_ok          (st_pop),
    .has_uncommitted (st_has_unc),
    .will_wb         (wb_ready),
    .wb_idx          (wb_idx),
    .to_wb           (st_pending_wb)
  );

  assign ld_full  = ld_count == LCW'(LQ_ENTRIES);
  assign st_full  = st_count == SCW'(SQ_ENTRIES);
  assign lsq_full = ld_full || st_full;

  always_comb begin
    int lf, sf;
    lf = int'(LQ_ENTRIES) - int'(ld_count);
    sf = int'(SQ_ENTRIES) - int'(st_count);
    free_entries = FW'((lf < sf) ? lf : sf);
  end

  // Insert acceptance and commit / squash walking.
  always_comb begin
    ld_ok  = ld_ins && !ld_full && !busy_q && !squash_req;
    st_ok  = st_ins && !st_full && !busy_q && !squash_req;
    err_d  = (ld_ins && !ld_ok) || (st_ins && !st_ok);
    cmt_en = cmt_v_q && !busy_q;
    ld_pop = cmt_en && (ld_count != '0) && (ld_head_seq <= cmt_bound_q);
    rm_ld  = busy_q && (ld_count != '0) && (ld_last_seq > sq_bound_q);
    rm_st  = busy_q && st_has_unc && (st_last_seq > sq_bound_q);

    cmt_v_d     = cmt_v_q || commit_req;
    cmt_bound_d = commit_req ? commit_seq : cmt_bound_q;
    sq_bound_d  = squash_req ? squash_seq : sq_bound_q;
    busy_d      = squash_req || (busy_q && (rm_ld || rm_st));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmt_v_q     <= 1'b0;
      cmt_bound_q <= '0;
      sq_bound_q  <= '0;
      busy_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      cmt_v_q     <= cmt_v_d;
      cmt_bound_q <= cmt_bound_d;
      sq_bound_q  <= sq_bound_d;
      busy_q      <= busy_d;
      err_q       <= err_d;
    end
  end

  assign squash_busy = busy_q;
  assign alloc_err   = err_q;

  a_r4_err_on_full: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ld_ins && ld_full) |=> alloc_err);
  a_r9_ld_shrink_only: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy_q |=> ld_count <= $past(ld_count));
  a_r9_st_shrink_only: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy_q |=> st_count <= $past(st_count));
  a_r3_free_bounded: assert property (@(posedge clk) disable iff (!rst_i_n)
    lsq_full |-> free_entries == '0);
endmodule

// File: tb/tb_lsq_occupancy.sv
module tb_lsq_occupancy;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NS = NE + 1;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_ins = 0, st_ins = 0, commit_req = 0, squash_req = 0, wb_send = 0, wb_done = 0;
  logic [SW-1:0] ld_ins_seq = 0, st_ins_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [2:0] ld_count, st_count, free_entries, st_pending_wb, wb_idx;
  logic [2:0] ld_head_idx, ld_tail_idx, st_head_idx, st_tail_idx;
  logic ld_full, st_full, lsq_full, wb_ready, squash_busy, alloc_err;

  int checks = 0, fails = 0;
  int lq[NS], sq[NS];
  int lh = 0, lc = 0, sh = 0, sc = 0, scm = 0, ssn = 0, bnd = 0;
  bit bv = 0;
  int gseq = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsq_occupancy #(.LQ_ENTRIES(NE), .SQ_ENTRIES(NE), .SEQ_W(SW)) dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic settle();
    if (bv) begin
      while (lc > 0 && lq[lh] <= bnd) begin lh = (lh + 1) % NS; lc--; end
      while (scm < sc && sq[(sh + scm) % NS] <= bnd) scm++;
    end
  endtask

  task automatic check_all();
    chk("R2", "ld_count", int'(ld_count), lc);
    chk("R2", "st_count", int'(st_count), sc);
    chk("R3", "ld_full", int'(ld_full), int'(lc == NE));
    chk("R3", "st_full", int'(st_full), int'(sc == NE));
    chk("R3", "lsq_full", int'(lsq_full), int'(lc == NE || sc == NE));
    chk("R3", "free_entries", int'(free_entries), min2(NE - lc, NE - sc));
    chk("R6", "st_pending_wb", int'(st_pending_wb), scm - ssn);
    chk("R7", "wb_ready", int'(wb_ready), int'(ssn < scm));
    chk("R7", "wb_idx", int'(wb_idx), (sh + ssn) % NS);
    chk("R10", "ld_head_idx", int'(ld_head_idx), lh);
    chk("R10", "ld_tail_idx", int'(ld_tail_idx), (lh + lc) % NS);
    chk("R10", "st_head_idx", int'(st_head_idx), sh);
    chk("R10", "st_tail_idx", int'(st_tail_idx), (sh + sc) % NS);
  endtask

  task automatic ins(bit is_st, int s);
    bit acc;
    if (is_st) begin
      st_ins = 1; st_ins_seq = SW'(s);
      chk("R2", "st tail before insert", int'(st_tail_idx), (sh + sc) % NS);
    end else begin
      ld_ins = 1; ld_ins_seq = SW'(s);
      chk("R2", "ld tail before insert", int'(ld_tail_idx), (lh + lc) % NS);
    end
    cyc();
    st_ins = 0; ld_ins = 0;
    if (is_st) begin
      acc = sc < NE;
      if (acc) begin sq[(sh + sc) % NS] = s; sc++; end
    end else begin
      acc = lc < NE;
      if (acc) begin lq[(lh + lc) % NS] = s; lc++; end
    end
    chk("R4", "alloc_err", int'(alloc_err), int'(!acc));
  endtask

  task automatic commit(int b);
    commit_req = 1; commit_seq = SW'(b);
    cyc();
    commit_req = 0;
    repeat (NE + 3) cyc();
    bnd = b; bv = 1;
    settle();
  endtask

  task automatic send();
    bit acc;
    acc = ssn < scm;
    wb_send = 1;
    cyc();
    wb_send = 0;
    if (acc) ssn++;
  endtask

  task automatic done();
    bit acc;
    acc = ssn > 0;
    wb_done = 1;
    cyc();
    wb_done = 0;
    if (acc) begin sh = (sh + 1) % NS; sc--; scm--; ssn--; end
  endtask

  task automatic squash_run(int b);
    squash_req = 1; squash_seq = SW'(b);
    cyc();
    squash_req = 0;
    chk("R9", "squash_busy after request", int'(squash_busy), 1);
    for (int k = 0; k < 20 && squash_busy; k++) cyc();
    chk("R9", "squash_busy falls", int'(squash_busy), 0);
    while (lc > 0 && lq[(lh + lc - 1) % NS] > b) lc--;
    while (sc > scm && sq[(sh + sc - 1) % NS] > b) sc--;
    settle();
  endtask

  initial begin
    int a, b, c, d, p, q, r, s, t, u;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R1: reset state
    check_all();
    chk("R1", "squash_busy", int'(squash_busy), 0);
    chk("R1", "alloc_err", int'(alloc_err), 0);
    chk("R1", "free_entries", int'(free_entries), NE);

    // R2 / R3: fill the load queue one at a time, then overfill (R4)
    for (int i = 0; i < NE; i++) begin ins(0, gseq); gseq++; check_all(); end
    ins(0, 99);
    check_all();
    // stores: fill and overfill
    for (int i = 0; i < NE; i++) begin ins(1, gseq); gseq++; check_all(); end
    ins(1, 99);
    check_all();

    // R5 / R6: commit bound covers all loads and first two stores
    commit(6);
    check_all();
    chk("R5", "loads freed by commit", int'(ld_count), 0);
    chk("R6", "stores kept after commit", int'(st_count), NE);

    // R8: done with nothing sent is ignored
    done();
    check_all();
    // R7: sends, then a send when not ready
    send(); check_all();
    send(); check_all();
    send(); check_all();
    chk("R7", "wb_idx after ignored send", int'(wb_idx), 2);
    done(); done(); check_all();
    done(); check_all();
    chk("R8", "st_count after ignored done", int'(st_count), 2);

    // R10: many rounds to wrap all pointers
    for (int it = 0; it < 12; it++) begin
      ins(0, gseq); gseq++;
      ins(1, gseq); gseq++;
      commit(gseq - 1);
      send(); done();
      check_all();
    end
    send(); send(); done(); done(); check_all();

    // R5: insert and free in the same cycle
    a = gseq++; b = gseq++; c = gseq++; d = gseq++;
    ins(0, a); ins(0, b); ins(0, c);
    commit_req = 1; commit_seq = SW'(b);
    cyc();
    commit_req = 0; ld_ins = 1; ld_ins_seq = SW'(d);
    cyc();
    ld_ins = 0;
    chk("R5", "net count on insert+free", int'(ld_count), 3);
    cyc();
    chk("R5", "second free", int'(ld_count), 2);
    repeat (NE) cyc();
    lq[(lh + lc) % NS] = d; lc++;
    bnd = b; bv = 1; settle();
    check_all();
    commit(d);
    check_all();

    // R9: squash in the middle of mixed loads and stores
    p = gseq++; q = gseq++; r = gseq++; s = gseq++; t = gseq++; u = gseq++;
    ins(0, p); ins(1, q); ins(0, r); ins(1, s); ins(0, t); ins(1, u);
    commit(q);
    check_all();
    squash_req = 1; squash_seq = SW'(r);
    cyc();
    squash_req = 0;
    chk("R9", "busy after request", int'(squash_busy), 1);
    ld_ins = 1; ld_ins_seq = SW'(gseq);
    cyc();
    ld_ins = 0;
    chk("R4", "insert during squash rejected", int'(alloc_err), 1);
    chk("R9", "one load removed per cycle", int'(ld_count), 1);
    chk("R9", "one store removed per cycle", int'(st_count), 2);
    for (int k = 0; k < 20 && squash_busy; k++) cyc();
    chk("R9", "busy falls", int'(squash_busy), 0);
    lc = 1; sc = 1;
    check_all();
    // R9: bound below a committed store
    squash_run(p);
    check_all();
    chk("R9", "committed store kept", int'(st_count), 1);

    // drain
    commit(gseq);
    send(); done();
    check_all();
    chk("R3", "free after drain", int'(free_entries), NE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule